// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a small processor-style configuration register file reached through two I/O ports. The first port is the index port: a write to it selects a register number. The second port is the data port: the next read or write on it moves a byte to or from the selected register. After every data-port access the selection is dropped, so each data-port access needs a fresh index write before it.

The file holds four control bytes, four non-cacheable region descriptors of three bytes each, and two read-only identification bytes. The identification bytes are a model code and a revision/stepping byte. A sticky lock bit in the fourth control byte works with a system-management flag input. While both are set, selected control bits are frozen. All stored contents are also driven out in parallel, so neighbouring logic can use them directly.

Top module: `cfg_index_port`

## Requirements
- R1: After reset, the control bytes at indices C0h to C3h read 00h. The region descriptor bytes at C4h to CFh read 00h, except index C6h, which reads 0Fh.
- R2: A write of an index to port 22h followed by a write to port 23h stores the data in that register. The parallel outputs show the new value from the next clock cycle.
- R3: A read on port 23h with a valid index returns the selected register's value in the same cycle as the read strobe.
- R4: Each data-port access invalidates the index. A data-port write with no valid index changes nothing. A data-port read with no valid index returns FFh.
- R5: Indices outside C0h to CFh, other than FEh and FFh, read as FFh, and writes to them have no effect.
- R6: Index FEh returns the model parameter (default 1Bh) and index FFh returns the revision/stepping parameter (default 13h). Writes to either have no effect.
- R7: Bits 7..5 of control byte C1h and bit 0 of control byte C2h always read 0, whatever is written to them.
- R8: Bit 0 of control byte C3h (the lock) is set by writing a 1. Writing a 0 does not clear it; only reset clears it.
- R9: While the lock is set and smm_active is high, writes leave bits 3..1 of C1h and bit 1 of C3h unchanged. The other writable bits of those bytes still take the written data.
- R10: With smm_active low, bits 3..1 of C1h and bit 1 of C3h are writable even while the lock is set.
- R11: The region descriptor byte at index C4h+k appears on ncr_o bits 8k+7 down to 8k, for k from 0 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port number of the current access |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, FFh when no mapped data read is active |
| smm_active | input | 1 | System-management mode is active |
| ccr0_o | output | 8 | Control byte C0h |
| ccr1_o | output | 8 | Control byte C1h |
| ccr2_o | output | 8 | Control byte C2h |
| ccr3_o | output | 8 | Control byte C3h |
| ncr_o | output | 96 | Region descriptor bytes C4h..CFh, lowest index in the low byte |

## Verification
Read data is combinational, so the bench samples io_rdata one nanosecond after it drives a read strobe, within the same cycle. Register writes and index updates take effect at the clock edge that ends the strobe cycle. The bench therefore looks at the parallel outputs and at read-backs only after that edge. The index invalidation is checked through a data-port access that follows another data-port access at the next cycle. A full sweep over all 256 indices compares each read-back with a value computed from the write masks.

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter logic [7:0] IDX_PORT = 8'h22,
  parameter logic [7:0] DAT_PORT = 8'h23,
  parameter logic [7:0] MODEL_ID = 8'h1B,
  parameter logic [7:0] REV_ID   = 8'h13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        smm_active,
  output logic [7:0]  ccr0_o,
  output logic [7:0]  ccr1_o,
  output logic [7:0]  ccr2_o,
  output logic [7:0]  ccr3_o,
  output logic [95:0] ncr_o
);
  localparam int NREG = 16;
  localparam logic [3:0] BASE_HI = 4'hC;

  logic [7:0] cfg [NREG];
  logic [7:0] idx_q;
  logic       idx_vld;

  wire idx_wr  = io_wr && io_addr == IDX_PORT;
  wire dat_wr  = io_wr && io_addr == DAT_PORT;
  wire dat_rd  = io_rd && io_addr == DAT_PORT;
  wire in_blk  = idx_q[7:4] == BASE_HI;
  wire locked  = cfg[3][0] && smm_active;
  wire [3:0] sel = idx_q[3:0];

  function automatic logic [7:0] wmask(input logic [3:0] i, input logic lk);
    case (i)
      4'd1:    wmask = lk ? 8'h11 : 8'h1F;
      4'd2:    wmask = 8'hFE;
      4'd3:    wmask = lk ? 8'hFD : 8'hFF;
      default: wmask = 8'hFF;
    endcase
  endfunction

  wire [7:0] msk  = wmask(sel, locked);
  wire [7:0] nval = (cfg[sel] & ~msk) | (io_wdata & msk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 8'h00;
      idx_vld <= 1'b0;
    end else if (idx_wr) begin
      idx_q   <= io_wdata;
      idx_vld <= 1'b1;
    end else if (dat_wr || dat_rd) begin
      idx_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cfg[i] <= (i == 6) ? 8'h0F : 8'h00;
    end else if (dat_wr && idx_vld && in_blk) begin
      if (sel == 4'd3) cfg[sel] <= {nval[7:1], cfg[3][0] | io_wdata[0]};
      else             cfg[sel] <= nval;
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (dat_rd && idx_vld) begin
      if (in_blk)               io_rdata = cfg[sel];
      else if (idx_q == 8'hFE)  io_rdata = MODEL_ID;
      else if (idx_q == 8'hFF)  io_rdata = REV_ID;
    end
  end

  assign ccr0_o = cfg[0];
  assign ccr1_o = cfg[1];
  assign ccr2_o = cfg[2];
  assign ccr3_o = cfg[3];

  for (genvar k = 0; k < 12; k++) begin : g_ncr
    assign ncr_o[8*k +: 8] = cfg[k+4];
  end

  AST_IDX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_wr || dat_rd) && !idx_wr) |=> !idx_vld); // R4
  AST_NOIDX_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_vld) |=> ($stable(ccr0_o) && $stable(ccr1_o) && $stable(ccr2_o)
                              && $stable(ccr3_o) && $stable(ncr_o))); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ccr3_o[0] |=> ccr3_o[0]); // R8
  AST_LOCK_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr3_o[0] && smm_active) |=> ccr1_o[3:1] == $past(ccr1_o[3:1])); // R9
  AST_LOCK_HOLD3: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr3_o[0] && smm_active) |=> ccr3_o[1] == $past(ccr3_o[1])); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr1_o[7:5] == 3'b000 && ccr2_o[0] == 1'b0)); // R7
  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && idx_vld && !in_blk && idx_q < 8'hFE) |-> io_rdata == 8'hFF); // R5
endmodule

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  io_addr = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic        smm_active = 0;
  logic [7:0]  ccr0_o, ccr1_o, ccr2_o, ccr3_o;
  logic [95:0] ncr_o;
  int errors = 0, checks = 0;
  bit done = 0;

  cfg_index_port u_cfg_index_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .smm_active(smm_active),
    .ccr0_o(ccr0_o), .ccr1_o(ccr1_o), .ccr2_o(ccr2_o), .ccr3_o(ccr3_o), .ncr_o(ncr_o));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk); io_addr = port; io_wdata = d; io_wr = 1;
    @(posedge clk); #1 io_wr = 0;
  endtask

  task automatic rd(input logic [7:0] port, output logic [7:0] d);
    @(negedge clk); io_addr = port; io_rd = 1;
    #1 d = io_rdata;
    @(posedge clk); #1 io_rd = 0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(8'h22, i); wr(8'h23, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    wr(8'h22, i); rd(8'h23, d);
  endtask

  function automatic logic [7:0] expect_sweep(input logic [7:0] i);
    logic [7:0] d = i ^ 8'h5A;
    if (i[7:4] == 4'hC) begin
      if (i == 8'hC1) return d & 8'h1F;
      if (i == 8'hC2) return d & 8'hFE;
      return d;
    end
    if (i == 8'hFE) return 8'h1B;
    if (i == 8'hFF) return 8'h13;
    return 8'hFF;
  endfunction

  task automatic do_reset;
    rst_n = 0; smm_active = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset values
    check("R1 ccr", {ccr0_o, ccr1_o, ccr2_o, ccr3_o}, 32'h0);
    check("R1 ncr", ncr_o, 96'h0F << 16);
    for (int i = 8'hC0; i <= 8'hCF; i++) begin
      reg_rd(8'(i), v);
      check($sformatf("R1 rd %0h", i), v, (i == 8'hC6) ? 8'h0F : 8'h00);
    end
    // R2 R3 R5 R6 R7 R11 full sweep
    for (int i = 0; i < 256; i++) begin
      reg_wr(8'(i), 8'(i) ^ 8'h5A);
      reg_rd(8'(i), v);
      check($sformatf("R2 R3 R5 R6 R7 idx %0h", i), v, expect_sweep(8'(i)));
      if (i >= 8'hC4 && i <= 8'hCF)
        check($sformatf("R11 ncr byte %0h", i), ncr_o[8*(i-8'hC4) +: 8], expect_sweep(8'(i)));
    end
    check("R2 ccr outputs", {ccr0_o, ccr1_o, ccr2_o, ccr3_o}, 32'h9A1B9899);
    check("R7 reserved", {ccr1_o[7:5], ccr2_o[0]}, 4'h0);
    // R4 index invalidation
    do_reset();
    reg_wr(8'hC0, 8'h3C);
    wr(8'h23, 8'h77);
    check("R4 write without index", ccr0_o, 8'h3C);
    rd(8'h23, v);
    check("R4 read without index", v, 8'hFF);
    reg_rd(8'hC0, v);
    rd(8'h23, v);
    check("R4 second read FF", v, 8'hFF);
    // R8 R9 R10 lock behaviour
    reg_wr(8'hC1, 8'h1E);
    reg_wr(8'hC3, 8'h03);
    smm_active = 1;
    reg_wr(8'hC1, 8'h00);
    check("R9 ccr1 held bits", ccr1_o, 8'h0E);
    reg_wr(8'hC3, 8'h00);
    check("R9 R8 ccr3", ccr3_o, 8'h03);
    reg_wr(8'hC3, 8'hF0);
    check("R9 ccr3 upper writable", ccr3_o, 8'hF3);
    reg_wr(8'hC1, 8'h11);
    check("R9 ccr1 bit4 bit0 writable", ccr1_o, 8'h1F);
    smm_active = 0;
    reg_wr(8'hC3, 8'h00);
    check("R10 R8 ccr3", ccr3_o, 8'h01);
    reg_wr(8'hC1, 8'h00);
    check("R10 ccr1", ccr1_o, 8'h00);
    do_reset();
    check("R8 reset clears lock", ccr3_o, 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule